// File: doc/BRIEF.md
# Reset Source Sequencer

This block combines every way a system reset can start into a single active-low system reset. The starting events are a power-on pulse, an external reset pin pulled low by the board, a watchdog timeout and a clock-monitor fault. The reset pin is bidirectional: the block pulls it low through an open-drain enable and reads its level back through a synchronizer.

A power-on event gives a long hold, counted in internal clock cycles, so that the clock can settle. Any other reset condition has a short sequence. The block pulls the pin low for a fixed number of E-clock ticks and releases it. It waits a further fixed number of ticks and then samples the pin. If the pin is still low at that sample, something outside holds it, and the cause is recorded as external. If the pin is high, the cause is the internal source that was latched: clock monitor or watchdog.

The 2-bit cause code selects the reset vector. While reset is asserted, the block also raises three preset outputs. These set the two interrupt mask bits and the stop-disable bit of the processor's condition codes.

Top module: `reset_source_sequencer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `sys_rst_n` is 0, `pin_drive_low` is 1 and `cause` is 2'b00.
- R2: After a `por_pulse` is sampled, `pin_drive_low` stays 1 for exactly POR_CYCLES (default 4064) clock cycles and then returns to 0. The cause becomes 2'b00.
- R3: A watchdog or clock-monitor request sampled while the block is idle sets `pin_drive_low` to 1. It stays 1 across exactly DRIVE_TICKS (default 4) E-clock ticks, counted as clock edges with `e_tick` high.
- R4: The synchronized pin is sampled on the SAMPLE_TICKS-th (default 2) E tick after release. If the pin is low at that sample, `cause` becomes 2'b00 (external), even when an internal request was latched.
- R5: If the pin is high at that sample, `cause` becomes 2'b01 when only the watchdog was latched and 2'b10 when the clock monitor was latched, with or without the watchdog. The code 2'b11 never appears.
- R6: A low level on the reset pin while the block is idle starts the short sequence. A pulse shorter than the sequence, with no internal request, ends with `cause` 2'b00.
- R7: After the sample, `sys_rst_n` stays 0 until the synchronized pin reads high. An external circuit that holds the pin low therefore holds the system in reset.
- R8: A watchdog or clock-monitor request that arrives during the drive window, the sample window or the release wait restarts the sequence. `pin_drive_low` is 1 in the next cycle and stays 1 for another full DRIVE_TICKS ticks. The new source is added to the latched sources.
- R9: A `por_pulse` sampled during a short sequence aborts it and starts the full POR_CYCLES hold. The cause becomes 2'b00.
- R10: Watchdog and clock-monitor requests during the power-on hold are ignored. The hold still lasts POR_CYCLES cycles and the cause becomes 2'b00.
- R11: `preset_xmask`, `preset_imask` and `preset_stopdis` are 1 whenever `sys_rst_n` is 0 and 0 whenever it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low block reset; treated like power-on |
| e_tick | input | 1 | One-cycle E-clock enable |
| por_pulse | input | 1 | One-cycle power-on event |
| wdog_timeout | input | 1 | Watchdog timeout request |
| clkmon_fault | input | 1 | Clock-monitor fault request |
| pin_level | input | 1 | Level read back from the reset pin (asynchronous) |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the reset pin low |
| sys_rst_n | output | 1 | Active-low system reset |
| cause | output | 2 | Reset cause: 00 external/power-on, 01 watchdog, 10 clock monitor |
| preset_xmask | output | 1 | Sets the non-maskable interrupt mask bit during reset |
| preset_imask | output | 1 | Sets the maskable interrupt mask bit during reset |
| preset_stopdis | output | 1 | Sets the stop-disable bit during reset |

## Verification
The hardest case to reach from the ports is a fresh request that lands inside the sample window. The block has released the pin but has not yet decided the cause. The bench waits until the drive output falls and one E tick has passed, then pulses the clock-monitor input. It checks that the drive comes back for a full window and that the latched watchdog and clock-monitor sources merge into code 10. The external-wins case is reached by holding the modelled pin low from outside across the sample while a watchdog request is pending. A power-on pulse is also injected in mid-sequence and in mid-hold to show that the long hold dominates.

// File: rtl/rsq_pkg.sv
// Shared types for the reset source sequencer.
// Assumes: cause codes are decoded by the vector-select logic outside this block.
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_POR_HOLD = 3'd1,
        ST_DRIVE    = 3'd2,
        ST_SAMPLE   = 3'd3,
        ST_REL_WAIT = 3'd4
    } rsq_state_e;

    localparam int CAUSE_W = 2;
    typedef logic [CAUSE_W-1:0] rsq_cause_t;

    localparam rsq_cause_t CAUSE_EXT    = 2'b00;
    localparam rsq_cause_t CAUSE_WDOG   = 2'b01;
    localparam rsq_cause_t CAUSE_CLKMON = 2'b10;

endpackage

// File: rtl/rsq_pin_sync.sv
// Multi-stage synchronizer for the asynchronous reset pin level.
// Assumes: STAGES >= 1; the reset value is 1, the pin's idle (pulled-up) level.
module rsq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw pin level through the chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rsq_window_counter.sv
// Counts step pulses from 0 to LIMIT-1 and flags the step that completes a window.
// Assumes: LIMIT >= 1; clear has priority over step; the count is 0 after clear.
module rsq_window_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign last = step && (cnt_q == TOP);

    // Advance the window count; wrap on the completing step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (step)       cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP); // R3

    AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clear) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/rsq_cause_latch.sv
// Latches which internal sources asked for reset and encodes the cause at the sample.
// Assumes: clear and set never need to coexist (the sequencer blocks sets while clearing);
// the clock monitor outranks the watchdog when both are latched.
module rsq_cause_latch
    import rsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       set_wdog,
    input  logic       set_clkmon,
    input  logic       pin_high,
    output rsq_cause_t cause_sel
);

    logic wdog_q;
    logic clkmon_q;

    // Remember each internal source until the sequence ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wdog_q   <= 1'b0;
            clkmon_q <= 1'b0;
        end else begin
            if (set_wdog)   wdog_q   <= 1'b1;
            if (set_clkmon) clkmon_q <= 1'b1;
        end
    end

    // Encode the cause from the pin sample and the latched sources.
    always_comb begin
        if (!pin_high)     cause_sel = CAUSE_EXT;
        else if (clkmon_q) cause_sel = CAUSE_CLKMON;
        else if (wdog_q)   cause_sel = CAUSE_WDOG;
        else               cause_sel = CAUSE_EXT;
    end

    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_q && !clear) |=> wdog_q); // R8

    AST_CAUSE_LEGAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        cause_sel != 2'b11); // R5

endmodule

// File: rtl/reset_source_sequencer.sv
// Merges the power-on, external-pin, watchdog and clock-monitor reset sources into one
// system reset. It drives the reset pin through an open-drain enable and decides the
// reset cause from a delayed pin sample.
// Assumes: e_tick is a one-cycle pulse at most every other clock; pin_level is the pin
// with an external pull-up; rst_n behaves like a power-on event.
module reset_source_sequencer
    import rsq_pkg::*;
#(
    parameter int POR_CYCLES   = 4064,
    parameter int DRIVE_TICKS  = 4,
    parameter int SAMPLE_TICKS = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e_tick,
    input  logic       por_pulse,
    input  logic       wdog_timeout,
    input  logic       clkmon_fault,
    input  logic       pin_level,
    output logic       pin_drive_low,
    output logic       sys_rst_n,
    output rsq_cause_t cause,
    output logic       preset_xmask,
    output logic       preset_imask,
    output logic       preset_stopdis
);

    rsq_state_e state_q, state_d;
    rsq_cause_t cause_q;
    rsq_cause_t cause_sel;
    logic       pin_s;
    logic       req_int;
    logic       in_short;
    logic       restart;
    logic       por_last, drive_last, samp_last;
    logic       decide;
    logic       src_clear;

    assign req_int  = wdog_timeout | clkmon_fault;
    assign in_short = (state_q == ST_DRIVE) || (state_q == ST_SAMPLE) ||
                      (state_q == ST_REL_WAIT);
    assign restart  = !por_pulse && in_short && req_int;
    assign decide   = !por_pulse && !restart && (state_q == ST_SAMPLE) && samp_last;

    rsq_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_level),
        .pin_sync  (pin_s)
    );

    rsq_window_counter #(
        .LIMIT (POR_CYCLES)
    ) u_por_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (por_pulse || (state_q != ST_POR_HOLD)),
        .step  (1'b1),
        .last  (por_last)
    );

    rsq_window_counter #(
        .LIMIT (DRIVE_TICKS)
    ) u_drive_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart || (state_q != ST_DRIVE)),
        .step  (e_tick),
        .last  (drive_last)
    );

    rsq_window_counter #(
        .LIMIT (SAMPLE_TICKS)
    ) u_samp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart || (state_q != ST_SAMPLE)),
        .step  (e_tick),
        .last  (samp_last)
    );

    assign src_clear = por_pulse || decide || (state_q == ST_POR_HOLD);

    rsq_cause_latch u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (src_clear),
        .set_wdog   (wdog_timeout && !src_clear && (state_q != ST_POR_HOLD)),
        .set_clkmon (clkmon_fault && !src_clear && (state_q != ST_POR_HOLD)),
        .pin_high   (pin_s),
        .cause_sel  (cause_sel)
    );

    // Choose the next sequencer state; power-on dominates, then restarts.
    always_comb begin
        state_d = state_q;
        if (por_pulse) begin
            state_d = ST_POR_HOLD;
        end else if (restart) begin
            state_d = ST_DRIVE;
        end else begin
            case (state_q)
                ST_IDLE:     if (req_int || !pin_s) state_d = ST_DRIVE;
                ST_POR_HOLD: if (por_last)          state_d = ST_REL_WAIT;
                ST_DRIVE:    if (drive_last)        state_d = ST_SAMPLE;
                ST_SAMPLE:   if (samp_last)         state_d = ST_REL_WAIT;
                ST_REL_WAIT: if (pin_s)             state_d = ST_IDLE;
                default:                            state_d = ST_POR_HOLD;
            endcase
        end
    end

    // Hold the sequencer state; block reset counts as power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_POR_HOLD;
        else        state_q <= state_d;
    end

    // Record the cause at the sample, or force external/power-on on the long hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      cause_q <= CAUSE_EXT;
        else if (por_pulse)                              cause_q <= CAUSE_EXT;
        else if ((state_q == ST_POR_HOLD) && por_last)   cause_q <= CAUSE_EXT;
        else if (decide)                                 cause_q <= cause_sel;
    end

    assign pin_drive_low  = (state_q == ST_POR_HOLD) || (state_q == ST_DRIVE);
    assign sys_rst_n      = (state_q == ST_IDLE);
    assign cause          = cause_q;
    assign preset_xmask   = !sys_rst_n;
    assign preset_imask   = !sys_rst_n;
    assign preset_stopdis = !sys_rst_n;

    AST_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_low |-> !sys_rst_n); // R1

    AST_POR_TAKES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |=> (pin_drive_low && (cause == CAUSE_EXT))); // R9

    AST_RESTART_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_short && req_int && !por_pulse) |=> pin_drive_low); // R8

    AST_RELEASE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(pin_s)); // R7

    AST_CAUSE_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && $past(sys_rst_n)) |-> $stable(cause)); // R5

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cause != 2'b11); // R5

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SAMPLE) && samp_last && !pin_s && !req_int && !por_pulse)
        |=> (cause == CAUSE_EXT)); // R4

endmodule

// File: tb/reset_source_sequencer_tb.sv
module reset_source_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int POR_N      = 4064;
    localparam int DRIVE_N    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e_tick = 1'b0;
    logic       por_pulse = 1'b0;
    logic       wdog_timeout = 1'b0;
    logic       clkmon_fault = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin_level;
    logic       pin_drive_low;
    logic       sys_rst_n;
    logic [1:0] cause;
    logic       preset_xmask, preset_imask, preset_stopdis;

    int checks = 0;
    int errors = 0;
    int div = 0;

    assign pin_level = !(pin_drive_low || ext_low);

    reset_source_sequencer u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .e_tick         (e_tick),
        .por_pulse      (por_pulse),
        .wdog_timeout   (wdog_timeout),
        .clkmon_fault   (clkmon_fault),
        .pin_level      (pin_level),
        .pin_drive_low  (pin_drive_low),
        .sys_rst_n      (sys_rst_n),
        .cause          (cause),
        .preset_xmask   (preset_xmask),
        .preset_imask   (preset_imask),
        .preset_stopdis (preset_stopdis)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            e_tick = (div == 3);
            div    = (div + 1) % 4;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!sys_rst_n && n < 20000) begin
            step();
            n++;
        end
        check("wait for release", sys_rst_n, 1);
    endtask

    task automatic pulse_req(input logic w, input logic c);
        wdog_timeout = w;
        clkmon_fault = c;
        step();
        wdog_timeout = 1'b0;
        clkmon_fault = 1'b0;
    endtask

    task automatic count_drive_ticks(output int n);
        int guard = 0;
        n = 0;
        while (pin_drive_low && guard < 2000) begin
            if (e_tick) n++;
            step();
            guard++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        check("R1 sys_rst_n in reset", sys_rst_n, 0);
        check("R1 pin drive in reset", pin_drive_low, 1);
        check("R1 cause in reset", cause, 0);
        check("R11 presets in reset", {preset_xmask, preset_imask, preset_stopdis}, 7);
        rst_n = 1'b1;
        step();
        check("R1 sys_rst_n after reset", sys_rst_n, 0);
        check("R1 pin drive after reset", pin_drive_low, 1);
        wait_idle();
        check("R11 presets when running", {preset_xmask, preset_imask, preset_stopdis}, 0);
        check("R1 cause after reset release", cause, 0);
    endtask

    task automatic t_por(input logic inject_mid);
        int n = 0;
        por_pulse = 1'b1;
        step();
        por_pulse = 1'b0;
        while (pin_drive_low && n < 10000) begin
            if (inject_mid && n == 100) begin
                clkmon_fault = 1'b1;
                wdog_timeout = 1'b1;
            end else begin
                clkmon_fault = 1'b0;
                wdog_timeout = 1'b0;
            end
            n++;
            step();
        end
        clkmon_fault = 1'b0;
        wdog_timeout = 1'b0;
        if (inject_mid) check("R10 hold length with requests", n, POR_N);
        else            check("R2 power-on hold length", n, POR_N);
        wait_idle();
        if (inject_mid) check("R10 cause after ignored requests", cause, 0);
        else            check("R2 cause after power-on", cause, 0);
    endtask

    task automatic t_internal(input logic w, input logic c, input int exp, input string req);
        int n;
        pulse_req(w, c);
        check("R3 drive starts on request", pin_drive_low, 1);
        count_drive_ticks(n);
        check("R3 drive window ticks", n, DRIVE_N);
        check("R7 still in reset before sample", sys_rst_n, 0);
        wait_idle();
        check(req, cause, exp);
    endtask

    task automatic t_ext_hold();
        ext_low = 1'b1;
        pulse_req(1'b1, 1'b0);
        for (int i = 0; i < 80; i++) step();
        check("R7 held in reset by external pin", sys_rst_n, 0);
        check("R7 pin released by block", pin_drive_low, 0);
        ext_low = 1'b0;
        wait_idle();
        check("R4 external wins over watchdog", cause, 0);
    endtask

    task automatic t_ext_short();
        ext_low = 1'b1;
        step(); step(); step();
        ext_low = 1'b0;
        step(); step();
        check("R6 short pin pulse starts sequence", sys_rst_n, 0);
        wait_idle();
        check("R6 short pin pulse cause", cause, 0);
    endtask

    task automatic t_restart();
        int n;
        int guard = 0;
        pulse_req(1'b1, 1'b0);
        while (pin_drive_low && guard < 200) begin
            step();
            guard++;
        end
        guard = 0;
        while (!e_tick && guard < 20) begin
            step();
            guard++;
        end
        step();
        pulse_req(1'b0, 1'b1);
        check("R8 restart redrives pin", pin_drive_low, 1);
        count_drive_ticks(n);
        check("R8 restarted window ticks", n, DRIVE_N);
        wait_idle();
        check("R8 merged sources cause", cause, 2);
    endtask

    task automatic t_por_mid();
        int n = 0;
        pulse_req(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step();
        por_pulse = 1'b1;
        step();
        por_pulse = 1'b0;
        check("R9 cause forced on power-on", cause, 0);
        while (pin_drive_low && n < 10000) begin
            n++;
            step();
        end
        check("R9 hold length after abort", n, POR_N);
        wait_idle();
        check("R9 cause after abort", cause, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_por(1'b0);
        t_internal(1'b1, 1'b0, 1, "R5 watchdog cause");
        t_internal(1'b0, 1'b1, 2, "R5 clock monitor cause");
        t_ext_hold();
        t_internal(1'b1, 1'b0, 1, "R5 watchdog cause again");
        t_ext_short();
        t_internal(1'b1, 1'b0, 1, "R5 watchdog before merge");
        t_internal(1'b1, 1'b1, 2, "R5 both sources give clock monitor");
        t_restart();
        t_por_mid();
        t_internal(1'b0, 1'b1, 2, "R5 clock monitor before hold");
        t_por(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule